// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles fit into one audio frame and uses that figure to pick the sampling speed mode (half, normal or double). Both clocks arrive asynchronously and are sampled by a free-running reference clock `clk`. A 2-bit control either forces one of the three speed modes or leaves the choice to the detector. Whichever way the mode is chosen, the detected ratio must be legal for it before the datapath is allowed to run.

The block also watches the master clock. If the master clock stops while the block is enabled, the block drops its internal run signal, and it raises that signal again on its own once the clock returns and the ratio has been measured again. A software run bit is carried over to the internal run signal only after a number of frame-clock edges, and that number differs between the falling and the rising direction. The outputs are the speed mode, a code for the detected ratio, a valid flag and a run signal that holds the datapath idle while low. Control, status and clock inputs are plain level pins, with no handshake.

Top module: `mclk_ratio_detector`

## Requirements
- R1: With `speed_sel_i` set to 00, 01 or 10, `speed_mode_o` follows it one cycle later. The encoding of both signals is 00 = normal, 01 = double, 10 = half. `speed_mode_o` never shows 11.
- R2: With `speed_sel_i` = 11 (automatic), a valid ratio of 1024 or 1536 selects half, 512 or 768 selects normal, and 128, 192, 256 or 384 selects double. While no valid ratio is present, the last mode is held.
- R3: The ratio is the count of master-clock rising edges between consecutive frame-clock rising edges. Its codes are 1=128, 2=192, 3=256, 4=384, 5=512, 6=768, 7=1024 and 8=1536. `ratio_valid_o` rises only after the same legal code has been measured on two consecutive frames. While the ratio is invalid, `ratio_code_o` reads 0.
- R4: A frame that measures a value not in that list, or a gap of more than 1536 master-clock edges with no frame-clock edge, clears `ratio_valid_o` and `core_run_o`.
- R5: In a forced mode, `core_run_o` is high only if the valid ratio is legal for that mode. Half accepts 512, 768, 1024 and 1536. Normal accepts 256, 384, 512 and 768. Double accepts 128, 192, 256 and 384.
- R6: If no master-clock edge is seen for `MCLK_TIMEOUT` reference cycles, `ratio_valid_o` and `core_run_o` go low. Once the clock returns and the ratio locks again, `core_run_o` comes back without any outside action.
- R7: While `rst_n` is low, every output reads 0 (mode normal). After release, `core_run_o` stays low until both clocks are present and the ratio has locked.
- R8: When `soft_run_i` falls, `core_run_o` falls at the 4th following frame-clock rising edge, which is 3 to 4 frame periods later. When `soft_run_i` rises, `core_run_o` returns at the 3rd such edge, which is 2 to 3 frame periods later.
- R9: A low `soft_run_i` leaves `ratio_valid_o` and `ratio_code_o` unchanged. A master-clock stop leaves the automatically chosen `speed_mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Power-down, active low, asynchronous |
| mclk_i | input | 1 | Master clock, asynchronous to `clk` |
| lrck_i | input | 1 | Frame clock, asynchronous to `clk` |
| speed_sel_i | input | 2 | 00 normal, 01 double, 10 half, 11 automatic |
| soft_run_i | input | 1 | Software run bit (1 = run) |
| speed_mode_o | output | 2 | Selected speed mode (same encoding as `speed_sel_i`) |
| ratio_code_o | output | 4 | Detected ratio code (0 = none) |
| ratio_valid_o | output | 1 | Ratio locked on two consecutive frames |
| core_run_o | output | 1 | Datapath run (low = held in reset) |

## Verification
The checker runs on every cycle and covers the following rules. Forced modes are mirrored on the output, and the automatic half and double choices follow the valid code. A valid flag never appears with an illegal code, and a run never appears without lock in the cycle before. Run is low whenever the master clock has been silent for longer than the timeout. The directed scenarios cover the behaviour that unfolds over several frames: the two-frame lock, the illegal-ratio and missing-frame-clock cases, and the legality sets of the forced modes. They also cover the resume after a clock stop, the asymmetric 4-edge and 3-edge delays of the software run bit, and the retention of the ratio and mode across soft reset and clock stop.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_HALF   = 2'b10,
    SPD_AUTO   = 2'b11
  } speed_e;

  localparam int RC_W = 4;

  // Count of master-clock edges per frame -> ratio code (0 = illegal)
  function automatic logic [RC_W-1:0] ratio_to_code(input logic [31:0] n);
    case (n)
      32'd128:  return 4'd1;
      32'd192:  return 4'd2;
      32'd256:  return 4'd3;
      32'd384:  return 4'd4;
      32'd512:  return 4'd5;
      32'd768:  return 4'd6;
      32'd1024: return 4'd7;
      32'd1536: return 4'd8;
      default:  return 4'd0;
    endcase
  endfunction

  // Automatic speed choice for a legal code
  function automatic speed_e auto_speed(input logic [RC_W-1:0] c);
    if (c >= 4'd7)      return SPD_HALF;
    else if (c >= 4'd5) return SPD_NORMAL;
    else                return SPD_DOUBLE;
  endfunction

  // Is code c acceptable under speed mode m
  function automatic logic code_allowed(input speed_e m, input logic [RC_W-1:0] c);
    case (m)
      SPD_HALF:   return c inside {4'd5, 4'd6, 4'd7, 4'd8};
      SPD_NORMAL: return c inside {4'd3, 4'd4, 4'd5, 4'd6};
      SPD_DOUBLE: return c inside {4'd1, 4'd2, 4'd3, 4'd4};
      default:    return c != 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/mrd_clock_watch.sv
module mrd_clock_watch #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic alive_o
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] idle_q;
  logic          alive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= '0;
      alive_q <= 1'b0;
    end else if (edge_i) begin
      idle_q  <= '0;
      alive_q <= 1'b1;
    end else if (idle_q == TW'(TIMEOUT)) begin
      alive_q <= 1'b0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  assign alive_o = alive_q;
endmodule

// File: rtl/mrd_ratio_meter.sv
module mrd_ratio_meter
  import mrd_pkg::*;
#(
  parameter int MAX_RATIO = 1536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclk_rise_i,
  input  logic            lrck_rise_i,
  input  logic            alive_i,
  output logic            valid_o,
  output logic [RC_W-1:0] code_o
);
  localparam int LIMIT = MAX_RATIO + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0]   cnt_q;
  logic [RC_W-1:0] prev_q, acc_q, cur;
  logic            valid_q;

  assign cur = ratio_to_code(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      prev_q  <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else if (!alive_i) begin
      cnt_q   <= '0;
      prev_q  <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else if (lrck_rise_i) begin
      // a coincident master edge belongs to the new frame
      cnt_q  <= mclk_rise_i ? CW'(1) : '0;
      prev_q <= cur;
      if (cur != '0 && cur == prev_q) begin
        acc_q   <= cur;
        valid_q <= 1'b1;
      end else begin
        acc_q   <= '0;
        valid_q <= 1'b0;
      end
    end else begin
      if (mclk_rise_i && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(LIMIT)) begin
        // frame clock missing
        prev_q  <= '0;
        acc_q   <= '0;
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign code_o  = acc_q;
endmodule

// File: rtl/mrd_run_ctrl.sv
module mrd_run_ctrl
  import mrd_pkg::*;
#(
  parameter int FALL_FRAMES = 4,
  parameter int RISE_FRAMES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lrck_rise_i,
  input  logic            alive_i,
  input  logic            valid_i,
  input  logic [RC_W-1:0] code_i,
  input  logic [1:0]      speed_sel_i,
  input  logic            soft_run_i,
  output logic [1:0]      speed_mode_o,
  output logic            core_run_o
);
  localparam int MAXF = (FALL_FRAMES > RISE_FRAMES) ? FALL_FRAMES : RISE_FRAMES;
  localparam int FW   = $clog2(MAXF + 1);

  speed_e        sel_e, mode_q;
  logic [FW-1:0] pend_q, need;
  logic          int_run_q, run_q, lock_ok;

  assign sel_e   = speed_e'(speed_sel_i);
  assign need    = soft_run_i ? FW'(RISE_FRAMES - 1) : FW'(FALL_FRAMES - 1);
  assign lock_ok = valid_i && code_allowed(sel_e, code_i);

  // frame-delayed carry of the software run bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_run_q <= 1'b1;
      pend_q    <= '0;
    end else if (soft_run_i == int_run_q) begin
      pend_q <= '0;
    end else if (lrck_rise_i) begin
      if (pend_q == need) begin
        int_run_q <= soft_run_i;
        pend_q    <= '0;
      end else begin
        pend_q <= pend_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SPD_NORMAL;
      run_q  <= 1'b0;
    end else begin
      if (sel_e != SPD_AUTO) mode_q <= sel_e;
      else if (valid_i)      mode_q <= auto_speed(code_i);
      run_q <= int_run_q && alive_i && lock_ok;
    end
  end

  assign speed_mode_o = mode_q;
  assign core_run_o   = run_q;
endmodule

// File: rtl/mclk_ratio_detector.sv
module mclk_ratio_detector
  import mrd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MAX_RATIO    = 1536,
  parameter int MCLK_TIMEOUT = 64,
  parameter int FALL_FRAMES  = 4,
  parameter int RISE_FRAMES  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_i,
  input  logic       lrck_i,
  input  logic [1:0] speed_sel_i,
  input  logic       soft_run_i,
  output logic [1:0] speed_mode_o,
  output logic [3:0] ratio_code_o,
  output logic       ratio_valid_o,
  output logic       core_run_o
);
  localparam int N_CLK = 2;

  logic [N_CLK-1:0] raw, rise;
  logic             alive, valid;
  logic [RC_W-1:0]  code;

  assign raw = {lrck_i, mclk_i};

  for (genvar g = 0; g < N_CLK; g++) begin : g_sync
    mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw[g]),
      .rise_o (rise[g])
    );
  end

  mrd_clock_watch #(.TIMEOUT(MCLK_TIMEOUT)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_i  (rise[0]),
    .alive_o (alive)
  );

  mrd_ratio_meter #(.MAX_RATIO(MAX_RATIO)) u_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclk_rise_i (rise[0]),
    .lrck_rise_i (rise[1]),
    .alive_i     (alive),
    .valid_o     (valid),
    .code_o      (code)
  );

  mrd_run_ctrl #(.FALL_FRAMES(FALL_FRAMES), .RISE_FRAMES(RISE_FRAMES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .lrck_rise_i  (rise[1]),
    .alive_i      (alive),
    .valid_i      (valid),
    .code_i       (code),
    .speed_sel_i  (speed_sel_i),
    .soft_run_i   (soft_run_i),
    .speed_mode_o (speed_mode_o),
    .core_run_o   (core_run_o)
  );

  assign ratio_code_o  = code;
  assign ratio_valid_o = valid;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int MCLK_TIMEOUT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mclk_i,
  input logic [1:0] speed_sel_i,
  input logic [1:0] speed_mode_o,
  input logic [3:0] ratio_code_o,
  input logic       ratio_valid_o,
  input logic       core_run_o
);
  logic [15:0] gap_q;
  logic        mclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      mclk_d <= 1'b0;
    end else begin
      mclk_d <= mclk_i;
      if (mclk_i != mclk_d)   gap_q <= '0;
      else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
    end
  end

  a_r1_forced_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_sel_i != 2'b11) |=> (speed_mode_o == $past(speed_sel_i)));

  a_r1_no_auto_out: assert property (@(posedge clk) disable iff (!rst_n)
    speed_mode_o != 2'b11);

  a_r2_auto_half: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_sel_i == 2'b11 && ratio_valid_o && ratio_code_o >= 4'd7) |=> (speed_mode_o == 2'b10));

  a_r2_auto_double: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_sel_i == 2'b11 && ratio_valid_o && ratio_code_o <= 4'd4) |=> (speed_mode_o == 2'b01));

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o |-> (ratio_code_o >= 4'd1 && ratio_code_o <= 4'd8));

  a_r3_code_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid_o |-> (ratio_code_o == 4'd0));

  a_r5_run_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    core_run_o |-> $past(ratio_valid_o));

  a_r6_stop_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q > 16'(MCLK_TIMEOUT + 10)) |-> !core_run_o);
endmodule

bind mclk_ratio_detector mrd_checker #(.MCLK_TIMEOUT(MCLK_TIMEOUT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mclk_i        (mclk_i),
  .speed_sel_i   (speed_sel_i),
  .speed_mode_o  (speed_mode_o),
  .ratio_code_o  (ratio_code_o),
  .ratio_valid_o (ratio_valid_o),
  .core_run_o    (core_run_o)
);

// File: tb/mclk_ratio_detector_test.sv
`timescale 1ns/1ps
module mclk_ratio_detector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mclk = 1'b0, lrck = 1'b0;
  logic       mclk_en = 1'b0, lrck_en = 1'b0;
  logic [1:0] sel = 2'b11;
  logic       soft_run = 1'b1;
  int         ratio_tb = 256;
  logic [1:0] speed_mode;
  logic [3:0] ratio_code;
  logic       ratio_valid, core_run;
  int         n_checks = 0, n_fail = 0;

  mclk_ratio_detector uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mclk_i        (mclk),
    .lrck_i        (lrck),
    .speed_sel_i   (sel),
    .soft_run_i    (soft_run),
    .speed_mode_o  (speed_mode),
    .ratio_code_o  (ratio_code),
    .ratio_valid_o (ratio_valid),
    .core_run_o    (core_run)
  );

  always #2 clk = ~clk;  // 250 MHz

  // master clock = 4 reference cycles; frame clock = ratio_tb master cycles
  initial begin : gen
    int mcnt;
    mcnt = 0;
    forever begin
      #8;
      if (mclk_en) begin
        mclk = ~mclk;
        if (mclk) begin
          mcnt++;
          if (mcnt >= ratio_tb / 2) begin
            mcnt = 0;
            if (lrck_en) lrck = ~lrck;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_frames(input int n);
    repeat (n) @(posedge lrck);
    wait_clk(10);
  endtask

  task automatic t_reset();
    mclk_en = 1'b1; lrck_en = 1'b1;
    wait_clk(20);
    check("R7 run in power-down", int'(core_run), 0);
    check("R7 valid in power-down", int'(ratio_valid), 0);
    check("R7 mode in power-down", int'(speed_mode), 0);
    check("R7 code in power-down", int'(ratio_code), 0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R7 run just after release", int'(core_run), 0);
    wait_frames(4);
    check("R3 valid after lock", int'(ratio_valid), 1);
    check("R3 code 256", int'(ratio_code), 3);
    check("R2 auto 256 double", int'(speed_mode), 1);
    check("R7 run after lock", int'(core_run), 1);
  endtask

  task automatic t_auto(input int ratio, input int exp_mode, input int exp_code);
    sel = 2'b11; ratio_tb = ratio;
    wait_frames(4);
    check($sformatf("R3 code for %0d", ratio), int'(ratio_code), exp_code);
    check($sformatf("R2 auto mode for %0d", ratio), int'(speed_mode), exp_mode);
    check($sformatf("R2 run for %0d", ratio), int'(core_run), 1);
  endtask

  task automatic t_illegal();
    int prev_mode;
    prev_mode = int'(speed_mode);
    ratio_tb = 300;
    wait_frames(4);
    check("R4 illegal ratio valid", int'(ratio_valid), 0);
    check("R4 illegal ratio code", int'(ratio_code), 0);
    check("R4 illegal ratio run", int'(core_run), 0);
    check("R2 mode held without lock", int'(speed_mode), prev_mode);
  endtask

  task automatic t_forced(input logic [1:0] s, input int ratio, input int exp_run);
    sel = s; ratio_tb = ratio;
    wait_frames(4);
    check($sformatf("R1 forced mode %0d", s), int'(speed_mode), int'(s));
    check($sformatf("R5 run mode %0d ratio %0d", s, ratio), int'(core_run), exp_run);
    check("R3 valid in forced mode", int'(ratio_valid), 1);
  endtask

  task automatic t_mclk_stop();
    sel = 2'b11; ratio_tb = 256;
    wait_frames(4);
    check("R6 running before stop", int'(core_run), 1);
    mclk_en = 1'b0;
    wait_clk(100);
    check("R6 run after stop", int'(core_run), 0);
    check("R6 valid after stop", int'(ratio_valid), 0);
    check("R9 mode kept over stop", int'(speed_mode), 1);
    mclk_en = 1'b1;
    wait_frames(4);
    check("R6 run after clock returns", int'(core_run), 1);
  endtask

  task automatic t_lrck_stop();
    lrck_en = 1'b0;
    wait_clk(7000);
    check("R4 valid without frame clock", int'(ratio_valid), 0);
    check("R4 run without frame clock", int'(core_run), 0);
    lrck_en = 1'b1;
    wait_frames(4);
    check("R4 run after frame clock returns", int'(core_run), 1);
  endtask

  task automatic t_soft();
    @(posedge lrck);
    wait_clk(20);
    soft_run = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge lrck);
      wait_clk(10);
      check($sformatf("R8 run kept at fall edge %0d", k), int'(core_run), 1);
    end
    @(posedge lrck);
    wait_clk(10);
    check("R8 run low at 4th edge", int'(core_run), 0);
    check("R9 valid kept in soft reset", int'(ratio_valid), 1);
    check("R9 code kept in soft reset", int'(ratio_code), 3);
    wait_clk(20);
    soft_run = 1'b1;
    for (int k = 1; k <= 2; k++) begin
      @(posedge lrck);
      wait_clk(10);
      check($sformatf("R8 run held low at rise edge %0d", k), int'(core_run), 0);
    end
    @(posedge lrck);
    wait_clk(10);
    check("R8 run back at 3rd edge", int'(core_run), 1);
  endtask

  task automatic t_powerdown();
    rst_n = 1'b0;
    wait_clk(5);
    check("R7 run in mid-run power-down", int'(core_run), 0);
    check("R7 mode in mid-run power-down", int'(speed_mode), 0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R7 run before relock", int'(core_run), 0);
    wait_frames(4);
    check("R7 run after relock", int'(core_run), 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_auto(1024, 2, 7);
    t_auto(512, 0, 5);
    t_auto(1536, 2, 8);
    t_auto(128, 1, 1);
    t_illegal();
    t_forced(2'b00, 256, 1);
    t_forced(2'b01, 512, 0);
    t_forced(2'b10, 256, 0);
    t_forced(2'b10, 512, 1);
    t_mclk_stop();
    t_lrck_stop();
    t_soft();
    t_powerdown();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule